// File: doc/BRIEF.md
# Decode-Side Constant Stash

This block is a small circular store that sits beside the instruction decoder and holds wide immediate values. Each value is up to 64 bits and may be an integer or a floating-point bit pattern. A micro-op therefore carries only a short slot number in place of the constant itself. Decode claims one slot for an ordinary instruction. It claims two adjacent slots for an instruction that needs a pair of constants, such as a store whose data and displacement are both immediates. Decode writes the values and forwards the number of the first slot.

When the back end issues the micro-op, it reads the constant by slot number. Each constant is consumed exactly once, so the read also releases the slot. Space is reclaimed in allocation order: the oldest pointer walks forward over released slots one per cycle. Misprediction recovery works through a few checkpoint registers that record the allocation pointer. Restoring one rewinds allocation to that point and discards every slot claimed after it.

Top module: `const_stash`

## Requirements
- R1: After reset, `free_slots` is 16, `full` is 0, `rd_valid` is 0 and `alloc_grant` is 0 while no request is made.
- R2: A single request (`alloc_req`=1, `alloc_pair`=0) with at least one free slot is granted in the same cycle. `alloc_idx` shows the slot, `alloc_val0` is stored there, and `free_slots` drops by one after the clock edge.
- R3: A pair request (`alloc_pair`=1) takes slots `alloc_idx` and `alloc_idx`+1 modulo 16, with `alloc_val0` in the first and `alloc_val1` in the second. With fewer than two free slots it is refused as a whole and no slot is taken.
- R4: When `free_slots` is 0, `full` is 1 and every request is refused, leaving the occupancy unchanged.
- R5: A read (`rd_en`=1, `rd_idx`) of an occupied slot gives `rd_valid`=1 and the stored 64-bit value on the cycle after the request.
- R6: A read releases its slot. A further read of that slot gives `rd_valid`=0 and changes nothing.
- R7: Capacity returns in allocation order. The oldest pointer advances by at most one slot per cycle over released slots, so a slot released ahead of an older occupied slot does not raise `free_slots`.
- R8: `ckpt_save` stores the allocation pointer into one of 4 checkpoint registers chosen by `ckpt_save_id`. The value stored is the pointer before any allocation granted in the same cycle.
- R9: `ckpt_restore` reloads the allocation pointer from the register chosen by `ckpt_restore_id` and releases every slot claimed after it, so reads of those slots give `rd_valid`=0. No request is granted in the restore cycle, and the next allocation starts at the restored slot.
- R10: If the oldest pointer has already moved past the restored pointer, the restore leaves the store empty (`free_slots` 16), with both pointers at the restored position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req | input | 1 | Request slot allocation this cycle |
| alloc_pair | input | 1 | Request two adjacent slots instead of one |
| alloc_val0 | input | 64 | Constant for the first slot |
| alloc_val1 | input | 64 | Constant for the second slot of a pair |
| alloc_grant | output | 1 | Allocation accepted this cycle |
| alloc_idx | output | 4 | Number of the first slot taken |
| rd_en | input | 1 | Consume the constant in slot `rd_idx` |
| rd_idx | input | 4 | Slot to consume |
| rd_valid | output | 1 | Registered: the previous read hit an occupied slot |
| rd_data | output | 64 | Registered constant returned by the previous read |
| ckpt_save | input | 1 | Record the allocation pointer |
| ckpt_save_id | input | 2 | Checkpoint register to write |
| ckpt_restore | input | 1 | Rewind the allocation pointer |
| ckpt_restore_id | input | 2 | Checkpoint register to restore from |
| full | output | 1 | No free slot |
| free_slots | output | 5 | Number of free slots, 0 to 16 |

## Verification
Several properties are checked in every cycle. Occupancy never exceeds the depth. A full store never grants. A restore cycle never grants, and it lands the allocation pointer on the recorded value. A read of an occupied slot leaves it empty. A returned value always follows a read request. The oldest pointer never jumps by more than one slot outside a restore. The bench scenarios cover what needs a history to show: the values carried by a pair that wraps past the last slot, in-order reclaim while an older slot is still held, the checkpoint value taken before a same-cycle allocation, and a restore behind an oldest pointer that has already moved on.

// File: rtl/cstash_pkg.sv
package cstash_pkg;
  localparam int unsigned CS_DEPTH = 16;
  localparam int unsigned CS_WIDTH = 64;
  localparam int unsigned CS_NCKPT = 4;

  typedef enum logic [1:0] {
    TAKE_NONE = 2'd0,
    TAKE_ONE  = 2'd1,
    TAKE_TWO  = 2'd2
  } take_e;
endpackage

// File: rtl/cstash_slots.sv
module cstash_slots #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 64,
  localparam int unsigned IW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr0_en,
  input  logic [IW-1:0]    wr0_idx,
  input  logic [WIDTH-1:0] wr0_val,
  input  logic             wr1_en,
  input  logic [IW-1:0]    wr1_idx,
  input  logic [WIDTH-1:0] wr1_val,
  input  logic [DEPTH-1:0] kill_mask,
  input  logic             rd_en,
  input  logic [IW-1:0]    rd_idx,
  output logic [DEPTH-1:0] occupied,
  output logic             rd_valid,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] store_q [DEPTH];
  logic [DEPTH-1:0] occ_q, occ_d;
  logic             rdv_q, rdv_d;
  logic [WIDTH-1:0] rdd_q;

  always_comb begin
    occ_d = occ_q;
    for (int i = 0; i < DEPTH; i++) begin
      if (kill_mask[i] || (rd_en && rd_idx == IW'(i))) occ_d[i] = 1'b0;
      if (wr0_en && wr0_idx == IW'(i)) occ_d[i] = 1'b1;
      if (wr1_en && wr1_idx == IW'(i)) occ_d[i] = 1'b1;
    end
    rdv_d = rd_en && occ_q[rd_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= '0;
      rdv_q <= 1'b0;
    end else begin
      occ_q <= occ_d;
      rdv_q <= rdv_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (wr0_en && wr0_idx == IW'(i)) store_q[i] <= wr0_val;
      else if (wr1_en && wr1_idx == IW'(i)) store_q[i] <= wr1_val;
    end
    if (rd_en) rdd_q <= store_q[rd_idx];
  end

  assign occupied = occ_q;
  assign rd_valid = rdv_q;
  assign rd_data  = rdd_q;

  // R6: consuming an occupied slot empties it
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && occ_q[rd_idx]) |=> !occ_q[$past(rd_idx)]);
  // R5: a returned value is always caused by a read in the prior cycle
  a_r5_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en));
endmodule

// File: rtl/cstash_ptrs.sv
module cstash_ptrs
  import cstash_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IW = $clog2(DEPTH),
  localparam int unsigned PW = IW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_req,
  input  logic             alloc_pair,
  input  logic             restore,
  input  logic [PW-1:0]    restore_ptr,
  input  logic [DEPTH-1:0] occupied,
  output logic             grant,
  output logic [PW-1:0]    tail,
  output logic [PW-1:0]    free_cnt,
  output logic [DEPTH-1:0] kill_mask,
  output logic             wr0_en,
  output logic [IW-1:0]    wr0_idx,
  output logic             wr1_en,
  output logic [IW-1:0]    wr1_idx
);
  logic [PW-1:0] head_q, head_d, tail_q, tail_d;
  logic [PW-1:0] occ, need, span, fwd_dist;
  logic          head_step;
  take_e         take;

  always_comb begin
    occ       = tail_q - head_q;
    free_cnt  = PW'(DEPTH) - occ;
    need      = alloc_pair ? PW'(2) : PW'(1);
    grant     = alloc_req && !restore && (free_cnt >= need);
    take      = !grant ? TAKE_NONE : (alloc_pair ? TAKE_TWO : TAKE_ONE);
    head_step = (occ != '0) && !occupied[head_q[IW-1:0]];
    span      = tail_q - restore_ptr;
    fwd_dist  = restore_ptr - head_q;
    for (int i = 0; i < DEPTH; i++) begin
      kill_mask[i] = restore &&
        ({1'b0, IW'(IW'(i) - restore_ptr[IW-1:0])} < span);
    end

    tail_d = tail_q;
    head_d = head_q;
    if (restore) begin
      tail_d = restore_ptr;
      if (fwd_dist > occ) head_d = restore_ptr;
    end else begin
      if (take == TAKE_ONE) tail_d = tail_q + PW'(1);
      else if (take == TAKE_TWO) tail_d = tail_q + PW'(2);
      if (head_step) head_d = head_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
    end
  end

  assign tail    = tail_q;
  assign wr0_en  = grant;
  assign wr0_idx = tail_q[IW-1:0];
  assign wr1_en  = grant && alloc_pair;
  assign wr1_idx = tail_q[IW-1:0] + IW'(1);

  // R4: occupancy never exceeds the depth
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_q - head_q) <= PW'(DEPTH));
  // R7: outside a restore the oldest pointer moves by at most one slot
  a_r7_head_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !restore |=> (PW'(head_q - $past(head_q)) <= PW'(1)));
endmodule

// File: rtl/cstash_ckpts.sv
module cstash_ckpts #(
  parameter int unsigned NCKPT = 4,
  parameter int unsigned PW    = 5,
  localparam int unsigned CW   = $clog2(NCKPT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          save,
  input  logic [CW-1:0] save_id,
  input  logic [PW-1:0] save_ptr,
  input  logic [CW-1:0] load_id,
  output logic [PW-1:0] load_ptr
);
  logic [PW-1:0] ck_q [NCKPT];

  for (genvar g = 0; g < NCKPT; g++) begin : g_ck
    logic          ck_en;
    logic [PW-1:0] ck_d;
    always_comb begin
      ck_en = save && (save_id == CW'(g));
      ck_d  = ck_en ? save_ptr : ck_q[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ck_q[g] <= '0;
      else        ck_q[g] <= ck_d;
    end
  end

  assign load_ptr = ck_q[load_id];
endmodule

// File: rtl/const_stash.sv
module const_stash
  import cstash_pkg::*;
#(
  parameter int unsigned DEPTH = CS_DEPTH,
  parameter int unsigned WIDTH = CS_WIDTH,
  parameter int unsigned NCKPT = CS_NCKPT,
  localparam int unsigned IW = $clog2(DEPTH),
  localparam int unsigned PW = IW + 1,
  localparam int unsigned CW = $clog2(NCKPT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_req,
  input  logic             alloc_pair,
  input  logic [WIDTH-1:0] alloc_val0,
  input  logic [WIDTH-1:0] alloc_val1,
  output logic             alloc_grant,
  output logic [IW-1:0]    alloc_idx,
  input  logic             rd_en,
  input  logic [IW-1:0]    rd_idx,
  output logic             rd_valid,
  output logic [WIDTH-1:0] rd_data,
  input  logic             ckpt_save,
  input  logic [CW-1:0]    ckpt_save_id,
  input  logic             ckpt_restore,
  input  logic [CW-1:0]    ckpt_restore_id,
  output logic             full,
  output logic [PW-1:0]    free_slots
);
  logic [1:0]       rst_sync;
  logic             rst_ni;
  logic [PW-1:0]    tail, restore_ptr;
  logic [DEPTH-1:0] occupied, kill_mask;
  logic             wr0_en, wr1_en;
  logic [IW-1:0]    wr0_idx, wr1_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  cstash_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst_n(rst_ni),
    .alloc_req(alloc_req), .alloc_pair(alloc_pair),
    .restore(ckpt_restore), .restore_ptr(restore_ptr),
    .occupied(occupied), .grant(alloc_grant), .tail(tail),
    .free_cnt(free_slots), .kill_mask(kill_mask),
    .wr0_en(wr0_en), .wr0_idx(wr0_idx),
    .wr1_en(wr1_en), .wr1_idx(wr1_idx)
  );

  cstash_slots #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_slots (
    .clk(clk), .rst_n(rst_ni),
    .wr0_en(wr0_en), .wr0_idx(wr0_idx), .wr0_val(alloc_val0),
    .wr1_en(wr1_en), .wr1_idx(wr1_idx), .wr1_val(alloc_val1),
    .kill_mask(kill_mask), .rd_en(rd_en), .rd_idx(rd_idx),
    .occupied(occupied), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  cstash_ckpts #(.NCKPT(NCKPT), .PW(PW)) u_ckpts (
    .clk(clk), .rst_n(rst_ni),
    .save(ckpt_save), .save_id(ckpt_save_id), .save_ptr(tail),
    .load_id(ckpt_restore_id), .load_ptr(restore_ptr)
  );

  assign alloc_idx = tail[IW-1:0];
  assign full      = (free_slots == '0);

  // R4: a full store grants nothing
  a_r4_full_no_grant: assert property (@(posedge clk) disable iff (!rst_ni)
    full |-> !alloc_grant);
  // R9: no grant in a restore cycle
  a_r9_restore_no_grant: assert property (@(posedge clk) disable iff (!rst_ni)
    ckpt_restore |-> !alloc_grant);
  // R9: allocation pointer lands on the recorded checkpoint value
  a_r9_restore_tail: assert property (@(posedge clk) disable iff (!rst_ni)
    ckpt_restore |=> (tail == $past(restore_ptr)));
endmodule

// File: tb/sim_const_stash.sv
`timescale 1ns/1ps
module sim_const_stash;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        alloc_req, alloc_pair;
  logic [63:0] alloc_val0, alloc_val1;
  logic        alloc_grant;
  logic [3:0]  alloc_idx;
  logic        rd_en;
  logic [3:0]  rd_idx;
  logic        rd_valid;
  logic [63:0] rd_data;
  logic        ckpt_save, ckpt_restore;
  logic [1:0]  ckpt_save_id, ckpt_restore_id;
  logic        full;
  logic [4:0]  free_slots;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  bit exp_due = 1'b0;

  bit          q_v   [$];
  logic [63:0] q_d   [$];
  string       q_tag [$];

  always #2.5 clk = ~clk;

  const_stash u0 (
    .clk(clk), .rst_n(rst_n),
    .alloc_req(alloc_req), .alloc_pair(alloc_pair),
    .alloc_val0(alloc_val0), .alloc_val1(alloc_val1),
    .alloc_grant(alloc_grant), .alloc_idx(alloc_idx),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_data(rd_data),
    .ckpt_save(ckpt_save), .ckpt_save_id(ckpt_save_id),
    .ckpt_restore(ckpt_restore), .ckpt_restore_id(ckpt_restore_id),
    .full(full), .free_slots(free_slots)
  );

  function automatic logic [63:0] kval(input int k);
    return 64'hA5C3_0000_0000_0000 | (64'(k) * 64'h0001_0000_0101);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic alloc(input bit pair, input logic [63:0] v0, input logic [63:0] v1,
                       input bit exp_g, input logic [3:0] exp_i, input string tag);
    @(posedge clk); #1;
    alloc_req = 1'b1; alloc_pair = pair; alloc_val0 = v0; alloc_val1 = v1;
    #1;
    check(alloc_grant == exp_g, {tag, " grant"}, 64'(alloc_grant), 64'(exp_g));
    if (exp_g) check(alloc_idx == exp_i, {tag, " index"}, 64'(alloc_idx), 64'(exp_i));
    @(posedge clk); #1;
    alloc_req = 1'b0; alloc_pair = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, input bit exp_v, input logic [63:0] exp_d,
                    input string tag);
    @(posedge clk); #1;
    rd_en = 1'b1; rd_idx = idx;
    q_v.push_back(exp_v); q_d.push_back(exp_d); q_tag.push_back(tag);
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic expect_free(input logic [4:0] n, input string tag);
    #1;
    check(free_slots == n, {tag, " free_slots"}, 64'(free_slots), 64'(n));
  endtask

  // Monitor: compares each read result with the scoreboard queue
  always @(posedge clk) exp_due <= rd_en;
  always @(negedge clk) begin
    if (exp_due) begin
      if (q_v.size() == 0) begin
        check(1'b0, "scoreboard empty", 64'(rd_valid), 64'd0);
      end else begin
        bit          ev;
        logic [63:0] ed;
        string       et;
        ev = q_v.pop_front(); ed = q_d.pop_front(); et = q_tag.pop_front();
        check(rd_valid == ev, {et, " rd_valid"}, 64'(rd_valid), 64'(ev));
        if (ev) check(rd_data == ed, {et, " rd_data"}, rd_data, ed);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    alloc_req = 1'b0; alloc_pair = 1'b0; alloc_val0 = '0; alloc_val1 = '0;
    rd_en = 1'b0; rd_idx = '0;
    ckpt_save = 1'b0; ckpt_save_id = '0; ckpt_restore = 1'b0; ckpt_restore_id = '0;
    idle(3); #1 rst_n = 1'b1;
    idle(4); #1;
    // R1 reset state
    check(free_slots == 5'd16, "R1 free_slots", 64'(free_slots), 64'd16);
    check(full == 1'b0, "R1 full", 64'(full), 64'd0);
    check(rd_valid == 1'b0, "R1 rd_valid", 64'(rd_valid), 64'd0);
    check(alloc_grant == 1'b0, "R1 grant", 64'(alloc_grant), 64'd0);

    // R2 single, R3 pair
    alloc(1'b0, kval(1), '0, 1'b1, 4'd0, "R2 single");
    expect_free(5'd15, "R2");
    alloc(1'b1, kval(2), kval(3), 1'b1, 4'd1, "R3 pair");
    expect_free(5'd13, "R3");
    // R5/R3 pair values; R7 out-of-order release keeps capacity
    rd(4'd2, 1'b1, kval(3), "R3 second of pair");
    rd(4'd1, 1'b1, kval(2), "R5 first of pair");
    idle(20);
    expect_free(5'd13, "R7 older slot still held");
    rd(4'd0, 1'b1, kval(1), "R5 oldest");
    idle(20);
    expect_free(5'd16, "R7 reclaimed in order");
    rd(4'd0, 1'b0, '0, "R6 second read");
    idle(2);
    expect_free(5'd16, "R6 no effect");

    // Fill with wrap: slots 3..14 single, pair over 15 and 0
    for (int i = 3; i < 15; i++) alloc(1'b0, kval(100 + i), '0, 1'b1, 4'(i), "R2 fill");
    expect_free(5'd4, "R2 fill");
    alloc(1'b1, kval(200), kval(201), 1'b1, 4'd15, "R3 wrapping pair");
    expect_free(5'd2, "R3 wrapping pair");
    alloc(1'b0, kval(202), '0, 1'b1, 4'd1, "R2 single");
    alloc(1'b1, kval(300), kval(301), 1'b0, 4'd0, "R3 pair refused");
    idle(1);
    expect_free(5'd1, "R3 refused pair took nothing");
    alloc(1'b0, kval(203), '0, 1'b1, 4'd2, "R2 last slot");
    #1;
    check(full == 1'b1, "R4 full", 64'(full), 64'd1);
    alloc(1'b0, kval(400), '0, 1'b0, 4'd0, "R4 refused");
    expect_free(5'd0, "R4 unchanged");

    rd(4'd0, 1'b1, kval(201), "R3 wrapped second");
    rd(4'd15, 1'b1, kval(200), "R3 wrapped first");
    for (int i = 3; i < 15; i++) rd(4'(i), 1'b1, kval(100 + i), "R5 drain");
    rd(4'd1, 1'b1, kval(202), "R5 drain");
    rd(4'd2, 1'b1, kval(203), "R5 drain");
    idle(20);
    expect_free(5'd16, "R7 drained");

    // R8: save ckpt 2 in the same cycle as an allocation at slot 3
    @(posedge clk); #1;
    ckpt_save = 1'b1; ckpt_save_id = 2'd2;
    alloc_req = 1'b1; alloc_pair = 1'b0; alloc_val0 = kval(500);
    #1;
    check(alloc_grant && alloc_idx == 4'd3, "R8 alloc with save", 64'(alloc_idx), 64'd3);
    @(posedge clk); #1;
    ckpt_save = 1'b0; alloc_req = 1'b0;
    alloc(1'b0, kval(501), '0, 1'b1, 4'd4, "R2 D");
    alloc(1'b0, kval(502), '0, 1'b1, 4'd5, "R2 E");
    @(posedge clk); #1;
    ckpt_save = 1'b1; ckpt_save_id = 2'd1;
    @(posedge clk); #1;
    ckpt_save = 1'b0;
    alloc(1'b0, kval(503), '0, 1'b1, 4'd6, "R2 F");

    // R9: restore ckpt 1 with a competing request
    @(posedge clk); #1;
    ckpt_restore = 1'b1; ckpt_restore_id = 2'd1;
    alloc_req = 1'b1; alloc_val0 = kval(600);
    #1;
    check(alloc_grant == 1'b0, "R9 grant in restore cycle", 64'(alloc_grant), 64'd0);
    @(posedge clk); #1;
    ckpt_restore = 1'b0; alloc_req = 1'b0;
    idle(2);
    expect_free(5'd13, "R9 after restore");
    rd(4'd6, 1'b0, '0, "R9 discarded slot");
    alloc(1'b0, kval(504), '0, 1'b1, 4'd6, "R9 next alloc at restored slot");
    rd(4'd3, 1'b1, kval(500), "R5 older slot survives");
    idle(3);

    // R10: restore ckpt 2 after the oldest pointer passed it
    @(posedge clk); #1;
    ckpt_restore = 1'b1; ckpt_restore_id = 2'd2;
    @(posedge clk); #1;
    ckpt_restore = 1'b0;
    idle(2);
    expect_free(5'd16, "R10 empty after restore");
    rd(4'd4, 1'b0, '0, "R10 discarded slot");
    alloc(1'b0, kval(700), '0, 1'b1, 4'd3, "R8 ckpt held pre-alloc pointer");
    rd(4'd3, 1'b1, kval(700), "R10 new slot readable");
    idle(3);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule